// File: doc/BRIEF.md
# Banked Memory Map Controller

This block is the address-mapping logic that sits between one 8-bit CPU and its memories. Behind the CPU's 16-bit address space are two 64K byte RAM banks and a boot PROM. A small select register, written with an I/O write, picks the active RAM bank and turns the PROM overlay on or off. The block decodes the CPU's address and its memory-request, I/O-request, read and write strobes into a RAM chip enable, a RAM bank select and a PROM chip enable.

A window at the top of the address space is common memory. It always maps to bank 0, whatever the bank bit says, so code and data placed there are seen from both banks. Reset turns the PROM overlay on, so the CPU starts executing from PROM at address 0000H.

While the overlay is on, reads below the PROM size come from the PROM. Writes to that range fall through to RAM in the selected bank, which lets a loader copy itself into RAM before it drops the overlay. The PROM size and the common window size are parameters.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset the select register holds bank 0 with the PROM overlay enabled, so a memory read at 0000H asserts prom_ce_o and not ram_ce_o.
- R2: An I/O write (iorq_i and wr_i high) whose port address bits [7:4] equal 4H loads the select register from sel_d_i on the clock edge. Bit 0 is the bank and bit 1 is the PROM enable. I/O writes to any other port, and I/O reads, leave the register unchanged.
- R3: For a RAM access outside the common window, ram_bank_o equals the register's bank bit (0 = bank 0, 1 = bank 1).
- R4: The common window covers the top COMMON_KB*1024 addresses. RAM accesses there drive ram_bank_o low whatever the bank bit holds.
- R5: With the overlay enabled, memory reads at addresses below PROM_KB*1024 assert prom_ce_o and not ram_ce_o. Reads at or above that size go to RAM.
- R6: With the overlay enabled, memory writes below PROM_KB*1024 assert ram_ce_o with the selected bank and never assert prom_ce_o.
- R7: With the overlay disabled, reads at low addresses assert ram_ce_o and never prom_ce_o.
- R8: A cycle asserts a chip enable only when mreq_i is high, iorq_i is low and exactly one of rd_i and wr_i is high. I/O cycles never assert a memory chip enable.
- R9: At most one of ram_ce_o and prom_ce_o is high, and prom_ce_o is high only during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address; bits [7:4] select the I/O port group |
| mreq_i | input | 1 | Memory cycle request |
| iorq_i | input | 1 | I/O cycle request |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| sel_d_i | input | 2 | Data bits D1..D0 written into the select register |
| ram_ce_o | output | 1 | RAM chip enable |
| ram_bank_o | output | 1 | RAM bank select, valid with ram_ce_o |
| prom_ce_o | output | 1 | PROM chip enable |

## Verification
The bench builds the block with a 4K PROM and a 2K common window. With these sizes the PROM edge (0FFFH/1000H) and the common edge (F7FFH/F800H) are both exercised in the same run. A behavioural model is compared on every cycle, so each edge is hit under both bank values and both overlay states. The stimulus mixes I/O writes to ports inside and just outside the 40H–4FH group, and adds mixed and idle strobe cases, so register updates and false decodes show up at the chip enables.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  typedef struct packed {
    logic prom_en;  // bit 1
    logic bank;     // bit 0
  } sel_t;

  localparam sel_t SEL_RESET = '{prom_en: 1'b1, bank: 1'b0};
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
  import bank_map_pkg::*;
#(
  parameter logic [3:0] PORT_NIB = 4'h4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       iorq_i,
  input  logic       wr_i,
  input  logic [3:0] port_nib_i,
  input  logic [1:0] sel_d_i,
  output sel_t       sel_o
);
  logic hit;
  sel_t sel_q;

  assign hit = iorq_i & wr_i & (port_nib_i == PORT_NIB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sel_q <= SEL_RESET;
    else if (hit) sel_q <= sel_t'(sel_d_i);
  end

  assign sel_o = sel_q;

  AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> sel_q == sel_t'($past(sel_d_i))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(sel_q)); // R2
endmodule

// File: rtl/bank_addr_decode.sv
module bank_addr_decode
  import bank_map_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PROM_KB   = 8,
  parameter int COMMON_KB = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_i,
  input  logic              iorq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  sel_t              sel_i,
  output logic              ram_ce_o,
  output logic              ram_bank_o,
  output logic              prom_ce_o
);
  localparam int PROM_AW   = $clog2(PROM_KB * 1024);
  localparam int COMMON_AW = $clog2(COMMON_KB * 1024);

  logic in_prom_win, in_common, access, prom_rd;

  // PROM window: all bits above the PROM size are zero
  generate
    if (PROM_AW >= ADDR_W) begin : g_prom_full
      assign in_prom_win = 1'b1;
    end else begin : g_prom_part
      assign in_prom_win = (addr_i[ADDR_W-1:PROM_AW] == '0);
    end
  endgenerate

  // Common window: all bits above the window size are one
  assign in_common = &addr_i[ADDR_W-1:COMMON_AW];

  assign access     = mreq_i & ~iorq_i & (rd_i ^ wr_i);
  assign prom_rd    = access & rd_i & sel_i.prom_en & in_prom_win;
  assign prom_ce_o  = prom_rd;
  assign ram_ce_o   = access & ~prom_rd;
  assign ram_bank_o = access & ~prom_rd & ~in_common & sel_i.bank;
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         PROM_KB   = 8,
  parameter int         COMMON_KB = 4,
  parameter logic [3:0] PORT_NIB  = 4'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_i,
  input  logic              iorq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        sel_d_i,
  output logic              ram_ce_o,
  output logic              ram_bank_o,
  output logic              prom_ce_o
);
  sel_t sel;

  bank_sel_reg #(.PORT_NIB(PORT_NIB)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iorq_i     (iorq_i),
    .wr_i       (wr_i),
    .port_nib_i (addr_i[7:4]),
    .sel_d_i    (sel_d_i),
    .sel_o      (sel)
  );

  bank_addr_decode #(
    .ADDR_W   (ADDR_W),
    .PROM_KB  (PROM_KB),
    .COMMON_KB(COMMON_KB)
  ) u_dec (
    .addr_i    (addr_i),
    .mreq_i    (mreq_i),
    .iorq_i    (iorq_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .sel_i     (sel),
    .ram_ce_o  (ram_ce_o),
    .ram_bank_o(ram_bank_o),
    .prom_ce_o (prom_ce_o)
  );

  AST_IO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iorq_i |-> !ram_ce_o && !prom_ce_o); // R8
  AST_ONE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_ce_o, prom_ce_o})); // R9
  AST_PROM_RD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prom_ce_o |-> rd_i && !wr_i && mreq_i); // R9
  AST_WR_TO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && !iorq_i && wr_i && !rd_i) |-> ram_ce_o); // R6
  AST_BANK_WITH_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_bank_o |-> ram_ce_o); // R3
endmodule

// File: tb/bank_map_ctrl_test.sv
`timescale 1ns/1ps
module bank_map_ctrl_test;
  localparam int PROM_KB   = 4;
  localparam int COMMON_KB = 2;
  localparam int PROM_TOP  = PROM_KB * 1024;
  localparam int COMMON_LO = 65536 - COMMON_KB * 1024;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        mreq = 1'b0, iorq = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  sel_d = '0;
  logic        ram_ce, ram_bank, prom_ce;

  int vectors = 0, errors = 0;
  int m_bank = 0, m_prom = 1;

  always #2.5 clk = ~clk;

  bank_map_ctrl #(.PROM_KB(PROM_KB), .COMMON_KB(COMMON_KB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .mreq_i(mreq), .iorq_i(iorq),
    .rd_i(rd), .wr_i(wr), .sel_d_i(sel_d),
    .ram_ce_o(ram_ce), .ram_bank_o(ram_bank), .prom_ce_o(prom_ce)
  );

  task automatic step(input logic m, input logic io, input logic r, input logic w,
                      input int a, input int d, input string req);
    int e_ram, e_bank, e_prom;
    bit acc;
    @(negedge clk);
    mreq = m; iorq = io; rd = r; wr = w; addr = 16'(a); sel_d = 2'(d);
    #1;
    acc    = m && !io && (r != w);
    e_prom = (acc && r && m_prom == 1 && a < PROM_TOP) ? 1 : 0;
    e_ram  = (acc && e_prom == 0) ? 1 : 0;
    e_bank = (e_ram == 1 && a < COMMON_LO) ? m_bank : 0;
    vectors++;
    if (int'(ram_ce) != e_ram || int'(ram_bank) != e_bank || int'(prom_ce) != e_prom) begin
      errors++;
      $display("FAIL %s addr=%04h m=%0d io=%0d r=%0d w=%0d: got ram_ce=%0d bank=%0d prom_ce=%0d, expected %0d %0d %0d",
               req, a, m, io, r, w, ram_ce, ram_bank, prom_ce, e_ram, e_bank, e_prom);
    end
    @(posedge clk);
    if (rst_ni && io && w && ((a >> 4) & 15) == 4) begin
      m_bank = d & 1;
      m_prom = (d >> 1) & 1;
    end
  endtask

  task automatic io_wr(input int port, input int d, input string req);
    step(1'b0, 1'b1, 1'b0, 1'b1, port, d, req);
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R1 reset state
    step(1, 0, 1, 0, 16'h0000, 0, "R1");
    step(1, 0, 1, 0, 16'h2000, 0, "R1");
    // R5 PROM edge
    step(1, 0, 1, 0, PROM_TOP - 1, 0, "R5");
    step(1, 0, 1, 0, PROM_TOP, 0, "R5");
    // R6 writes under overlay go to RAM
    step(1, 0, 0, 1, 16'h0010, 0, "R6");
    // R8 I/O and idle cycles
    step(0, 1, 1, 0, 16'h0000, 0, "R8");
    step(0, 0, 1, 0, 16'h0000, 0, "R8");
    step(1, 0, 1, 1, 16'h0000, 0, "R8");
    step(1, 1, 1, 0, 16'h0000, 0, "R8");
    // R2 writes outside 40H-4FH ignored, seen at outputs
    io_wr(16'h0030, 1, "R2");
    step(1, 0, 1, 0, 16'h0000, 0, "R2");
    io_wr(16'h0050, 1, "R2");
    step(1, 0, 0, 1, 16'h4000, 0, "R2");
    step(0, 1, 1, 0, 16'h0045, 1, "R2");
    step(1, 0, 0, 1, 16'h4000, 0, "R2");
    // R2/R3 select bank 1, keep PROM
    io_wr(16'h004F, 3, "R2");
    step(1, 0, 0, 1, 16'h4000, 0, "R3");
    step(1, 0, 0, 1, 16'h0000, 0, "R6");
    step(1, 0, 1, 0, 16'h0000, 0, "R5");
    // R4 common window edge
    step(1, 0, 1, 0, COMMON_LO - 1, 0, "R4");
    step(1, 0, 1, 0, COMMON_LO, 0, "R4");
    step(1, 0, 0, 1, 16'hFFFF, 0, "R4");
    // R7 overlay off
    io_wr(16'h0040, 1, "R2");
    step(1, 0, 1, 0, 16'h0000, 0, "R7");
    step(1, 0, 1, 0, PROM_TOP - 1, 0, "R7");
    io_wr(16'h1248, 0, "R2");
    step(1, 0, 1, 0, 16'h0100, 0, "R7");
    step(1, 0, 1, 0, 16'h8000, 0, "R3");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int kind, a;
      kind = int'($urandom_range(0, 9));
      case ($urandom_range(0, 5))
        0: a = int'($urandom_range(0, PROM_TOP + 3));
        1: a = int'($urandom_range(PROM_TOP - 3, PROM_TOP + 3));
        2: a = int'($urandom_range(COMMON_LO - 3, COMMON_LO + 3));
        3: a = int'($urandom_range(COMMON_LO, 65535));
        4: a = int'($urandom_range(16'h0030, 16'h005F));
        default: a = int'($urandom_range(0, 65535));
      endcase
      case (kind)
        0, 1: io_wr(a, int'($urandom_range(0, 3)), "R2");
        2:    step(0, 1, 1, 0, a, int'($urandom_range(0, 3)), "R8");
        3:    step(0, 0, $urandom_range(0, 1), $urandom_range(0, 1), a, 0, "R8");
        4, 5, 6: step(1, 0, 1, 0, a, 0, "R5");
        default: step(1, 0, 0, 1, a, 0, "R6");
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule